// File: doc/BRIEF.md
# Indexed Widening Reduction-Sum Unit

This unit is a reduction datapath for a vector engine with 128-bit registers. Each request brings sixteen signed 16-bit elements. These are typically the widened products of two 16-byte signed 8-bit operands. The unit sign-extends every element to 32 bits and adds them all together. It also adds the 32-bit accumulator value held in one lane of the destination register. The total is written back into that same lane, and the lane is chosen by a 2-bit index. The response is the whole updated 128-bit destination register.

A plain widening reduction always targets lane 0. Because this unit can target any lane, four successive reductions with indices 0 to 3 pack four dot-product results into one register, with no separate insert step. The result equals a plain widening reduction followed by inserting the scalar into the chosen lane of the destination.

The pipeline takes one request per cycle and answers two cycles later. The caller's copy of the destination is stale while an earlier result is still in flight. A chain flag on the request therefore tells the unit to take the destination contents from its own most recent result instead of the supplied value.

Top module: `idxred_unit`

## Requirements
- R1: The new value of the selected lane equals the sum of all sixteen source elements, each sign-extended to 32 bits, plus the previous value of that lane.
- R2: Source element i occupies bits [16i+15:16i] of `src_elems` and is a two's-complement number.
- R3: Destination lane k occupies bits [32k+31:32k] of the 128-bit register, and `lane_idx` = k (0 to 3) selects lane k as the lane that is updated.
- R4: The three lanes that `lane_idx` does not select leave the unit equal to their values in the base register.
- R5: `out_valid` rises exactly two cycles after each accepted `in_valid`. Requests may arrive on every cycle, and each one yields exactly one response.
- R6: With `chain_prev` = 1, the base register is the most recent result the unit produced, and `dst_in` has no effect. With `chain_prev` = 0, the base register is `dst_in`.
- R7: After reset, `out_valid` is 0 and the stored result is all zeros. A chained request issued first therefore starts from a zero register.
- R8: The lane arithmetic wraps modulo 2^32, with no saturation.
- R9: While `out_valid` is 0, `dst_out` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_elems | input | 256 | Sixteen signed 16-bit source elements |
| dst_in | input | 128 | Current destination register contents |
| lane_idx | input | 2 | Destination lane to update |
| chain_prev | input | 1 | Use the unit's last result as the base instead of `dst_in` |
| out_valid | output | 1 | Response strobe |
| dst_out | output | 128 | Updated destination register |

## Verification
The sum is tried with several source patterns, and each one separates a different error:
- All zeros isolates the accumulator path.
- All maximum-positive and all maximum-negative elements expose a missing or wrong sign extension.
- A single non-zero element, swept across all sixteen positions, catches element mis-ordering or dropped terms in the tree.
- Pseudo-random elements mix signs.

Each pattern is run for every lane index, both unchained and as a back-to-back chain of four. This shows whether a chained request sees the lane written by the request just before it. A lane preloaded near 2^31 shows wrap-around.

// File: rtl/idxred_pkg.sv
package idxred_pkg;
    localparam int SRC_N   = 16;
    localparam int SRC_W   = 16;
    localparam int ACC_W   = 32;
    localparam int DST_N   = 4;
    localparam int GRP_N   = 4;
    localparam int IDX_W   = $clog2(DST_N);
    localparam int SRC_BUS = SRC_N * SRC_W;
    localparam int DST_BUS = DST_N * ACC_W;
    localparam int PER_GRP = SRC_N / GRP_N;

    typedef logic [GRP_N-1:0][ACC_W-1:0] part_vec_t;

    typedef struct packed {
        logic               chain;
        logic [IDX_W-1:0]   idx;
        logic [DST_BUS-1:0] dst;
        part_vec_t          part;
    } stage_t;

    function automatic logic [ACC_W-1:0] widen(input logic [SRC_W-1:0] v);
        return {{(ACC_W-SRC_W){v[SRC_W-1]}}, v};
    endfunction
endpackage

// File: rtl/idxred_tree.sv
module idxred_tree
    import idxred_pkg::*;
(
    input  logic [SRC_BUS-1:0] src,
    output part_vec_t          part
);
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        always_comb begin
            part[g] = '0;
            for (int e = 0; e < PER_GRP; e++) begin
                part[g] = part[g] + widen(src[(g*PER_GRP+e)*SRC_W +: SRC_W]);
            end
        end
    end
endmodule

// File: rtl/idxred_merge.sv
module idxred_merge
    import idxred_pkg::*;
(
    input  logic [DST_BUS-1:0] base,
    input  logic [IDX_W-1:0]   idx,
    input  logic [ACC_W-1:0]   total,
    output logic [DST_BUS-1:0] merged
);
    for (genvar k = 0; k < DST_N; k++) begin : g_lane
        logic hit;
        assign hit = (idx == IDX_W'(k));
        assign merged[k*ACC_W +: ACC_W] = hit ? base[k*ACC_W +: ACC_W] + total
                                              : base[k*ACC_W +: ACC_W];
    end
endmodule

// File: rtl/idxred_unit.sv
module idxred_unit
    import idxred_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [SRC_BUS-1:0] src_elems,
    input  logic [DST_BUS-1:0] dst_in,
    input  logic [IDX_W-1:0]   lane_idx,
    input  logic               chain_prev,
    output logic               out_valid,
    output logic [DST_BUS-1:0] dst_out
);
    part_vec_t          part_c;
    stage_t             s1;
    logic               s1_valid;
    logic [ACC_W-1:0]   total_c;
    logic [DST_BUS-1:0] base_c;
    logic [DST_BUS-1:0] merged_c;

    idxred_tree i_tree (.src(src_elems), .part(part_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1       <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1.chain <= chain_prev;
                s1.idx   <= lane_idx;
                s1.dst   <= dst_in;
                s1.part  <= part_c;
            end
        end
    end

    always_comb begin
        total_c = '0;
        for (int g = 0; g < GRP_N; g++) total_c = total_c + s1.part[g];
    end

    assign base_c = s1.chain ? dst_out : s1.dst;

    idxred_merge i_merge (.base(base_c), .idx(s1.idx), .total(total_c), .merged(merged_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_out   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) dst_out <= merged_c;
        end
    end

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid); // R5
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(dst_out)); // R9

    for (genvar k = 0; k < DST_N; k++) begin : g_keep
        AST_KEEP_LANE: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && !s1.chain && s1.idx != IDX_W'(k)) |=>
            dst_out[k*ACC_W +: ACC_W] == $past(s1.dst[k*ACC_W +: ACC_W])); // R4
    end
endmodule

// File: tb/test_idxred_unit.sv
module test_idxred_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [255:0] src_elems;
    logic [127:0] dst_in;
    logic [1:0]   lane_idx;
    logic         chain_prev;
    logic         out_valid;
    logic [127:0] dst_out;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    idxred_unit i_idxred_unit (.*);

    logic [127:0] model_last;
    logic [127:0] seen_last;
    logic         p0_v, p1_v;
    logic [127:0] p0_d, p1_d;
    string        p0_t, p1_t;

    function automatic logic [31:0] src_total(input logic [255:0] s);
        logic [31:0] t = '0;
        for (int i = 0; i < 16; i++) t = t + {{16{s[16*i+15]}}, s[16*i +: 16]};
        return t;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [255:0] s, input logic [127:0] d,
                         input logic [1:0] ix, input logic ch, input string tag);
        logic [127:0] base, res;
        @(negedge clk);
        if (out_valid !== p1_v) begin
            checks++; failures++;
            $display("FAIL R5 out_valid act=%b exp=%b", out_valid, p1_v);
        end else checks++;
        if (p1_v) begin
            check(p1_t, dst_out, p1_d);
            seen_last = p1_d;
        end else check("R9 idle hold", dst_out, seen_last);
        p1_v = p0_v; p1_d = p0_d; p1_t = p0_t;
        in_valid = v; src_elems = s; dst_in = d; lane_idx = ix; chain_prev = ch;
        p0_v = v; p0_t = tag;
        if (v) begin
            base = ch ? model_last : d;
            res = base;
            res[32*ix +: 32] = base[32*ix +: 32] + src_total(s);
            model_last = res;
            p0_d = res;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0, '0, 2'd0, 1'b0, "idle");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [255:0] pats [5];
        logic [255:0] s;
        rst = 1'b1; in_valid = 0; src_elems = '0; dst_in = '0; lane_idx = 0; chain_prev = 0;
        model_last = '0; seen_last = '0;
        p0_v = 0; p1_v = 0; p0_d = '0; p1_d = '0; p0_t = ""; p1_t = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset valid", {127'd0, out_valid}, 128'd0);
        check("R7 reset data", dst_out, 128'd0);
        rst = 1'b0;
        // R7: first chained request builds on an all-zero register
        cycle(1, {16{16'h0003}}, {4{32'hFFFF_FFFF}}, 2'd2, 1'b1, "R7 R6 chain from reset");
        idle(3);
        pats[0] = '0;
        pats[1] = {16{16'h7FFF}};
        pats[2] = {16{16'h8000}};
        for (int i = 0; i < 16; i++) pats[3][16*i +: 16] = 16'(i * 301 - 2000);
        pats[4] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        for (int p = 0; p < 5; p++) begin
            // R1 R3 R4: each lane, unchained, preloaded distinct lanes
            for (int ix = 0; ix < 4; ix++)
                cycle(1, pats[p], {32'h4444_0004, 32'hC333_0003, 32'h0222_0002, 32'h8111_0001},
                      2'(ix), 1'b0, "R1 R3 R4 unchained lane");
            // R6: back-to-back chain of four fills all lanes; dst_in junk is ignored
            cycle(1, pats[p], 128'd0, 2'd0, 1'b0, "R6 chain head");
            for (int ix = 1; ix < 4; ix++)
                cycle(1, pats[p], {4{32'hDEAD_BEEF}}, 2'(ix), 1'b1, "R6 chained lane");
            cycle(1, pats[p], {4{32'h1234_5678}}, 2'd1, 1'b1, "R6 R1 chained accumulate");
            idle(2);
        end
        // R2: one non-zero element swept through every position
        for (int e = 0; e < 16; e++) begin
            s = '0;
            s[16*e +: 16] = 16'(16'h0100 + e - 16'h4000 * (e % 2));
            cycle(1, s, {32'd7, 32'd5, 32'd3, 32'd1}, 2'(e % 4), 1'b0, "R2 element position");
        end
        // R8: wrap past 2^31 and past 2^32
        cycle(1, {16{16'h7FFF}}, {96'd0, 32'h7FFF_FFF0}, 2'd0, 1'b0, "R8 wrap positive");
        cycle(1, {16{16'h8000}}, {32'h8000_0010, 96'd0}, 2'd3, 1'b0, "R8 wrap negative");
        cycle(1, {16{16'h0010}}, {32'd0, 32'hFFFF_FF80, 64'd0}, 2'd2, 1'b0, "R8 wrap through zero");
        // R9: gaps between requests keep last result
        idle(3);
        cycle(1, pats[3], 128'd0, 2'd1, 1'b1, "R6 R9 chain after gap");
        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule